// File: doc/BRIEF.md
# Banked Interrupt Register Block

This block gathers interrupt sources into four byte-wide banks and presents them to software through a small synchronous register bus. Two general-purpose banks (A and B) each carry eight sources. A DMA bank carries six sources. A fast bank carries eight sources. Every bank offers three views: the raw status, a mask that software enables source by source, and the masked request.

Bank A turns each rising edge of a source into a sticky latch. Software drops a latch by writing ones to the request offset of bank A. Banks B, DMA and fast report their inputs as levels and ignore clears. Requests from banks A, B and DMA combine into the normal interrupt line. Requests from the fast bank drive the fast interrupt line. The choice between sources and any vectoring are left to the consumer of these lines.

Top module: `irq_bank_regs`

## Requirements
- R1: Address bits [5:4] select the bank (0 = A, 1 = B, 2 = DMA, 3 = fast). Address bits [3:0] select the register: 0x0 is raw status, 0x4 is request and 0x8 is mask. Any other offset reads as zero.
- R2: After reset, all four masks read as zero, and both irqOut and fiqOut are low.
- R3: A mask read returns exactly the value last written to that mask. Writing one bank's mask leaves every other mask unchanged.
- R4: Each bit of a request read equals the matching status bit ANDed with the matching mask bit.
- R5: A bank A status bit sets on the clock edge that first samples its source high. It stays set after the source falls, and it is not yet visible before that edge.
- R6: Writing a byte to offset 0x4 of bank A clears the bank A latches at the one bits of that byte. Latches at the zero bits are left as they are.
- R7: When a bank A source rises in the same cycle that a clear of the same bit is written, the bit ends up set.
- R8: The status of banks B, DMA and fast follows the inputs as levels. Writes to their offset 0x4 change nothing.
- R9: The DMA bank uses bits 0 to 5. Bits 6 and 7 of its status, request and mask always read as zero.
- R10: irqOut is high exactly when any request bit of banks A, B or DMA is set. fiqOut is high exactly when any fast bank request bit is set.
- R11: Writes to the status offset 0x0 of any bank have no effect on status or mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Register address: bank in [5:4], register in [3:0] |
| busWrEn | input | 1 | Write strobe, acts on the rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| srcA | input | 8 | Bank A sources, edge-latched |
| srcB | input | 8 | Bank B sources, level |
| srcDma | input | 6 | DMA bank sources, level |
| srcFast | input | 8 | Fast bank sources, level |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
The level banks are driven with a table of source and mask pairs. The pairs cover full overlap, no overlap (alternating bits against their complement) and partial overlap. Together they show that the request is a bitwise AND and not a plain OR of the sources. The table also shows that each line listens only to its own banks. A DMA entry writes all ones to the mask, which exposes any leak into bits 6 and 7. Directed sequences on bank A then check three things: that a short pulse is held after the source falls, that a selective clear keeps the bits that were not named, and that a rise landing in the same cycle as a clear survives it. Writes to offsets that must be ignored are followed by read-backs of the state they could have disturbed.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int NumBanks = 4;

  localparam int BankA    = 0;
  localparam int BankB    = 1;
  localparam int BankDma  = 2;
  localparam int BankFast = 3;

  localparam int OffStatus  = 0;
  localparam int OffRequest = 4;
  localparam int OffMask    = 8;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_REQUEST = 2'd1,
    SEL_MASK    = 2'd2,
    SEL_NONE    = 2'd3
  } rdSelT;

  typedef struct packed {
    logic [NumBanks-1:0] maskWr;
    logic                clrA;
    logic [1:0]          rdBank;
    rdSelT               rdSel;
  } strobeT;

endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobeT            strobes
);

  localparam int OffW = ADDR_W - 2;

  logic [1:0]      bankSel;
  logic [OffW-1:0] regOff;

  assign bankSel = busAddr[ADDR_W-1 -: 2];
  assign regOff  = busAddr[OffW-1:0];

  always_comb begin
    strobes        = '0;
    strobes.rdBank = bankSel;
    strobes.rdSel  = SEL_NONE;
    if (int'(regOff) == OffStatus) begin
      strobes.rdSel = SEL_STATUS;
    end else if (int'(regOff) == OffRequest) begin
      strobes.rdSel = SEL_REQUEST;
      strobes.clrA  = busWrEn && (int'(bankSel) == BankA);
    end else if (int'(regOff) == OffMask) begin
      strobes.rdSel = SEL_MASK;
      strobes.maskWr[bankSel] = busWrEn;
    end
  end

  // R1: no more than one mask written per cycle
  assert_onehot_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.maskWr));

  // R8: a clear strobe only ever comes from a bank A address
  assert_clear_only_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrA |-> (busAddr[ADDR_W-1 -: 2] == 2'd0) && busWrEn);

endmodule

// File: rtl/irqEdgeLatch.sv
module irqEdgeLatch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] src,
  input  logic         clrStrobe,
  input  logic [W-1:0] clrBits,
  output logic [W-1:0] held
);

  logic [W-1:0] srcPrev;
  logic [W-1:0] setVec;
  logic [W-1:0] clrVec;

  assign setVec = src & ~srcPrev;
  assign clrVec = clrStrobe ? clrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev <= '0;
      held    <= '0;
    end else begin
      srcPrev <= src;
      held    <= (held & ~clrVec) | setVec;
    end
  end

  // R7: every newly risen source is set on the next cycle, clear or not
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((held & $past(setVec)) == $past(setVec)));

  // R6: a cleared bit without a new rise is gone on the next cycle
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |=> ((held & $past(clrBits & ~setVec)) == '0));

  // R5: with no clear, latched bits never drop
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clrStrobe |=> ((held & $past(held)) == $past(held)));

endmodule

// File: rtl/irqMaskBank.sv
module irqMaskBank #(
  parameter int DATA_W = 8,
  parameter int LIVE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawIn,
  input  logic              maskWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] maskOut,
  output logic [DATA_W-1:0] reqOut
);

  localparam logic [DATA_W-1:0] LiveBits = DATA_W'((64'd1 << LIVE_W) - 64'd1);

  logic [DATA_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else if (maskWr) maskQ <= wrData & LiveBits;
  end

  assign statusOut = rawIn & LiveBits;
  assign maskOut   = maskQ;
  assign reqOut    = statusOut & maskQ;

  // R3: a mask holds its value whenever it is not written
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(maskQ));

  // R4: a request bit never appears without its mask bit
  assert_req_in_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut & ~maskQ) == '0);

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DMA_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DMA_W-1:0]  srcDma,
  input  logic [DATA_W-1:0] srcFast,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut
);

  logic [DATA_W-1:0] rawVal  [NumBanks];
  logic [DATA_W-1:0] statVal [NumBanks];
  logic [DATA_W-1:0] maskVal [NumBanks];
  logic [DATA_W-1:0] reqVal  [NumBanks];

  irqEdgeLatch #(.W(DATA_W)) latchA_i (
    .clk       (clk),
    .rstN      (rstN),
    .src       (srcA),
    .clrStrobe (strobes.clrA),
    .clrBits   (wrData),
    .held      (rawVal[BankA])
  );

  assign rawVal[BankB]    = srcB;
  assign rawVal[BankDma]  = DATA_W'(srcDma);
  assign rawVal[BankFast] = srcFast;

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    localparam int LiveW = (b == BankDma) ? DMA_W : DATA_W;
    irqMaskBank #(.DATA_W(DATA_W), .LIVE_W(LiveW)) bank_i (
      .clk       (clk),
      .rstN      (rstN),
      .rawIn     (rawVal[b]),
      .maskWr    (strobes.maskWr[b]),
      .wrData    (wrData),
      .statusOut (statVal[b]),
      .maskOut   (maskVal[b]),
      .reqOut    (reqVal[b])
    );
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_STATUS:  rdData = statVal[strobes.rdBank];
      SEL_REQUEST: rdData = reqVal[strobes.rdBank];
      SEL_MASK:    rdData = maskVal[strobes.rdBank];
      default:     rdData = '0;
    endcase
  end

  assign irqOut = |(reqVal[BankA] | reqVal[BankB] | reqVal[BankDma]);
  assign fiqOut = |reqVal[BankFast];

  // R10: the normal line needs at least one enabled source in its banks
  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((maskVal[BankA] | maskVal[BankB] | maskVal[BankDma]) != '0));

  // R10: the fast line needs at least one enabled fast source
  assert_fiq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (maskVal[BankFast] != '0));

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DMA_W  = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DMA_W-1:0]  srcDma,
  input  logic [DATA_W-1:0] srcFast,
  output logic              irqOut,
  output logic              fiqOut
);

  strobeT strobes;

  irqCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  irqDatapath #(.DATA_W(DATA_W), .DMA_W(DMA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .srcA    (srcA),
    .srcB    (srcB),
    .srcDma  (srcDma),
    .srcFast (srcFast),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: tb/irq_bank_regs_tb.sv
module irq_bank_regs_tb_top;

  localparam int ClkPeriod = 10;
  localparam int NumVec    = 8;

  typedef struct packed {
    logic [1:0] bank;
    logic [7:0] src;
    logic [7:0] mask;
    logic [7:0] expMask;
    logic [7:0] expReq;
    logic       expIrq;
    logic       expFiq;
  } vecT;

  // R4 / R9 / R10 table on the level banks
  localparam vecT Vecs [NumVec] = '{
    '{2'd1, 8'hA5, 8'hFF, 8'hFF, 8'hA5, 1'b1, 1'b0},
    '{2'd1, 8'hA5, 8'h5A, 8'h5A, 8'h00, 1'b0, 1'b0},
    '{2'd1, 8'hF0, 8'h30, 8'h30, 8'h30, 1'b1, 1'b0},
    '{2'd2, 8'h3F, 8'hFF, 8'h3F, 8'h3F, 1'b1, 1'b0},
    '{2'd2, 8'h21, 8'h01, 8'h01, 8'h01, 1'b1, 1'b0},
    '{2'd2, 8'h00, 8'hFF, 8'h3F, 8'h00, 1'b0, 1'b0},
    '{2'd3, 8'h81, 8'h80, 8'h80, 8'h80, 1'b0, 1'b1},
    '{2'd3, 8'h81, 8'h7E, 8'h7E, 8'h00, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] srcA = '0;
  logic [7:0] srcB = '0;
  logic [5:0] srcDma = '0;
  logic [7:0] srcFast = '0;
  logic       irqOut;
  logic       fiqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  irq_bank_regs dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .srcA      (srcA),
    .srcB      (srcB),
    .srcDma    (srcDma),
    .srcFast   (srcFast),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [5:0] addr, input logic [7:0] data);
    busAddr   = addr;
    busWrData = data;
    busWrEn   = 1'b1;
    tick();
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] addr, output logic [7:0] data);
    busAddr = addr;
    #1;
    data = busRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R2: reset state
    for (int b = 0; b < 4; b++) begin
      busRead(6'(b * 16 + 8), rd);
      check("R2 mask after reset", rd, 8'h00);
    end
    check("R2 irqOut after reset", {7'd0, irqOut}, 8'h00);
    check("R2 fiqOut after reset", {7'd0, fiqOut}, 8'h00);

    // R4 R9 R10: walk the table over the level banks
    for (int i = 0; i < NumVec; i++) begin
      @(negedge clk);
      case (Vecs[i].bank)
        2'd1: srcB = Vecs[i].src;
        2'd2: srcDma = Vecs[i].src[5:0];
        default: srcFast = Vecs[i].src;
      endcase
      busWrite({Vecs[i].bank, 4'h8}, Vecs[i].mask);
      busRead({Vecs[i].bank, 4'h8}, rd);
      check("R3 R9 table mask readback", rd, Vecs[i].expMask);
      busRead({Vecs[i].bank, 4'h4}, rd);
      check("R4 table request", rd, Vecs[i].expReq);
      check("R10 table irqOut", {7'd0, irqOut}, {7'd0, Vecs[i].expIrq});
      check("R10 table fiqOut", {7'd0, fiqOut}, {7'd0, Vecs[i].expFiq});
      @(negedge clk);
      busWrite({Vecs[i].bank, 4'h8}, 8'h00);
      srcB = '0;
      srcDma = '0;
      srcFast = '0;
    end

    // R9: DMA status upper bits
    @(negedge clk);
    srcDma = 6'h3F;
    busRead(6'h20, rd);
    check("R9 DMA status width", rd, 8'h3F);
    srcDma = '0;

    // R1: unused offset reads zero
    busRead(6'h0C, rd);
    check("R1 unused offset", rd, 8'h00);

    // R3: bank A mask, others untouched
    @(negedge clk);
    busWrite(6'h08, 8'h96);
    busRead(6'h08, rd);
    check("R3 bank A mask readback", rd, 8'h96);
    busRead(6'h18, rd);
    check("R3 bank B mask untouched", rd, 8'h00);

    // R11: status write ignored
    @(negedge clk);
    busWrite(6'h10, 8'hFF);
    busRead(6'h10, rd);
    check("R11 bank B status after write", rd, 8'h00);
    busRead(6'h18, rd);
    check("R11 bank B mask after status write", rd, 8'h00);

    // R5: rising edge latch with timing
    @(negedge clk);
    srcA = 8'h04;
    busRead(6'h00, rd);
    check("R5 status before edge", rd, 8'h00);
    @(negedge clk);
    busRead(6'h00, rd);
    check("R5 status after edge", rd, 8'h04);
    srcA = 8'h00;
    @(negedge clk);
    busRead(6'h00, rd);
    check("R5 status held after source falls", rd, 8'h04);
    busRead(6'h04, rd);
    check("R4 bank A request", rd, 8'h04);
    check("R10 irqOut from bank A", {7'd0, irqOut}, 8'h01);

    // R6: clears
    @(negedge clk);
    busWrite(6'h04, 8'h04);
    busRead(6'h00, rd);
    check("R6 full clear", rd, 8'h00);
    srcA = 8'h14;
    tick();
    srcA = 8'h00;
    tick();
    busWrite(6'h04, 8'h10);
    busRead(6'h00, rd);
    check("R6 selective clear", rd, 8'h04);
    busWrite(6'h04, 8'hFF);

    // R7: set wins over clear
    srcA = 8'h01;
    busWrite(6'h04, 8'h01);
    busRead(6'h00, rd);
    check("R7 set beats clear", rd, 8'h01);
    srcA = 8'h00;
    tick();

    // R4: masked-off status still visible in status, not request
    busWrite(6'h08, 8'h00);
    busRead(6'h04, rd);
    check("R4 request with mask off", rd, 8'h00);
    busRead(6'h00, rd);
    check("R4 status with mask off", rd, 8'h01);

    // R8: clear write on a level bank ignored
    @(negedge clk);
    srcB = 8'h0F;
    busWrite(6'h14, 8'hFF);
    busRead(6'h10, rd);
    check("R8 bank B status after clear write", rd, 8'h0F);
    srcB = 8'h00;
    busRead(6'h10, rd);
    check("R8 bank B follows level", rd, 8'h00);

    finishRun();
  end

endmodule